// File: doc/BRIEF.md
# Power Mode Clock-Gating Controller

This controller decides which sections of a display-oriented microcontroller receive a clock. The supplies stay on throughout, and power is saved by removing clocks one section at a time. Software sets three control bits through a write port: standby, idle and power-down. The block turns these bits into registered clock enables for four domains. The domains are the CPU, the acquisition unit, the display unit and the peripheral group (memory interface, I2C, timers, watchdog, UART, ADC and PWM). A fifth output tells the oscillator whether to run.

Several events end a low-power state. An enabled pending interrupt or an ADC threshold-compare event ends idle, and the block clears the idle bit itself. An external reset ends any state, but only after it has been held for a fixed number of consecutive clocks. An enabled wake event or a qualified reset ends power-down. After power-down the oscillator restarts first, and every clock enable stays off until a programmable stabilization count has run out. The oscillator and the comparator are outside this block. They appear here as a free-running timebase `clk` and as event inputs.

An FSM holds the mode in one of four states:
- `PM_RUN`: all sections clocked, except that acquisition and display are also off when standby is set.
- `PM_IDLE`: the CPU is also stopped.
- `PM_PDOWN`: the oscillator is stopped.
- `PM_OSCWAIT`: the oscillator is running and the block is waiting out the stabilization count.

The transitions are:
- write-pdown: RUN to PDOWN.
- write-idle: RUN to IDLE.
- wake: IDLE to RUN.
- pdown-exit: PDOWN to OSCWAIT.
- stable: OSCWAIT to RUN.
- reset: RUN or IDLE to RUN, and PDOWN to OSCWAIT.

Top module: `pwr_mode_gate`

## Requirements
- R1: In PM_RUN with the standby bit set, `clk_en_acq` and `clk_en_disp` are 0, while `clk_en_cpu`, `clk_en_per` and `osc_run` are 1. With standby clear, all five are 1.
- R2: While the idle bit is set, `clk_en_cpu`, `clk_en_acq` and `clk_en_disp` are 0, and `clk_en_per` and `osc_run` are 1.
- R3: While the power-down bit is set, `osc_run` and all four clock enables are 0.
- R4: Standby may be written together with idle or power-down. After a wake from either, the CPU clock returns, but acquisition and display stay gated as long as standby remains 1.
- R5: In idle, a pending interrupt whose enable bit is 1 (`irq_pend & irq_en` nonzero) clears the idle bit at the next clock edge and restores the CPU clock. A pending interrupt whose enable bit is 0 has no effect.
- R6: In idle, `cmp_wake` ends idle in the same way as an enabled interrupt.
- R7: `rst_out` rises on the clock edge that samples `ext_rst` high for the 24th consecutive time. It stays high while `ext_rst` stays high. A run of 23 high samples or fewer never asserts it.
- R8: While `rst_out` is 1, the next edge clears standby, idle and power-down. From idle or run, the block returns to run. After power-on reset, all enables are 1 and all bits are 0.
- R9: On leaving power-down, `osc_run` is 1 and all clock enables are 0 for exactly `stab_len`+1 cycles. After that the block is in run.
- R10: Power-down ends on an enabled interrupt, on `cmp_wake`, or on a qualified reset.
- R11: A write with both `wr_idle` and `wr_pdown` set enters power-down, and the idle bit stays 0.
- R12: A write is accepted only while the CPU clock is enabled. In any other state, `wr_en` leaves all three bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase standing in for the oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Control-bit write strobe |
| wr_stby | input | 1 | Standby value to write |
| wr_idle | input | 1 | Idle request to write |
| wr_pdown | input | 1 | Power-down request to write |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Interrupt enable mask |
| cmp_wake | input | 1 | ADC threshold-compare wake event |
| ext_rst | input | 1 | External reset request, unqualified |
| stab_len | input | STAB_W | Stabilization count loaded on leaving power-down |
| osc_run | output | 1 | Oscillator run enable |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_acq | output | 1 | Acquisition clock enable |
| clk_en_disp | output | 1 | Display clock enable |
| clk_en_per | output | 1 | Peripheral group clock enable |
| rst_out | output | 1 | Qualified reset |
| stby_bit | output | 1 | Standby control bit |
| idle_bit | output | 1 | Idle control bit |
| pdown_bit | output | 1 | Power-down control bit |

## Verification
The assertions check on every cycle that the enables agree with the mode bits. This covers the standby, idle and power-down gating, and the rule that acquisition is off whenever standby is set and the CPU is running. They also check that idle is left one edge after an enabled interrupt or a compare event, and that a combined idle and power-down write lands in power-down. Against an independent run-length counter, they check that `rst_out` matches 24 consecutive high samples of `ext_rst`, and that a qualified reset clears every bit. The exact length of the stabilization window, the rejection of writes while the CPU is gated, and masked interrupts that leave idle untouched are shown by the bench scenarios. Those scenarios are compared cycle by cycle against the bench's own model of the mode sequence.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_IDLE    = 2'd1,
        PM_PDOWN   = 2'd2,
        PM_OSCWAIT = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int QUAL = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst,
    output logic rst_q
);
    localparam int CW = $clog2(QUAL + 1);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            rst_q   <= 1'b0;
        end else begin
            if (!ext_rst)
                run_cnt <= '0;
            else if (run_cnt != CW'(QUAL))
                run_cnt <= run_cnt + 1'b1;
            rst_q <= ext_rst && (run_cnt >= CW'(QUAL - 1));
        end
    end
endmodule

// File: rtl/pmc_stab_timer.sv
module pmc_stab_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_stby,
    input  logic             wr_idle,
    input  logic             wr_pdown,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             cmp_wake,
    input  logic             rst_q,
    input  logic             stab_done,
    output logic             stab_load,
    output logic             osc_run,
    output logic             en_cpu,
    output logic             en_acq,
    output logic             en_disp,
    output logic             en_per,
    output logic             stby_bit,
    output logic             idle_bit,
    output logic             pdown_bit
);
    pm_state_e state, nxt;
    logic      stby_q, stby_n, wake;

    assign wake = (|(irq_pend & irq_en)) | cmp_wake;

    // next-state and standby-bit decision
    always_comb begin
        nxt    = state;
        stby_n = stby_q;
        if (rst_q) begin
            stby_n = 1'b0;
            unique case (state)
                PM_PDOWN:   nxt = PM_OSCWAIT;
                PM_OSCWAIT: nxt = stab_done ? PM_RUN : PM_OSCWAIT;
                default:    nxt = PM_RUN;
            endcase
        end else begin
            unique case (state)
                PM_RUN: begin
                    if (wr_en) begin
                        stby_n = wr_stby;
                        if (wr_pdown)     nxt = PM_PDOWN;
                        else if (wr_idle) nxt = PM_IDLE;
                    end
                end
                PM_IDLE:    if (wake)      nxt = PM_RUN;
                PM_PDOWN:   if (wake)      nxt = PM_OSCWAIT;
                PM_OSCWAIT: if (stab_done) nxt = PM_RUN;
            endcase
        end
    end

    assign stab_load = (nxt == PM_OSCWAIT) && (state != PM_OSCWAIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PM_RUN;
            stby_q <= 1'b0;
        end else begin
            state  <= nxt;
            stby_q <= stby_n;
        end
    end

    // registered gating enables, updated on the same edge as the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_run <= 1'b1;
            en_cpu  <= 1'b1;
            en_acq  <= 1'b1;
            en_disp <= 1'b1;
            en_per  <= 1'b1;
        end else begin
            osc_run <= (nxt != PM_PDOWN);
            en_cpu  <= (nxt == PM_RUN);
            en_acq  <= (nxt == PM_RUN) && !stby_n;
            en_disp <= (nxt == PM_RUN) && !stby_n;
            en_per  <= (nxt == PM_RUN) || (nxt == PM_IDLE);
        end
    end

    assign stby_bit  = stby_q;
    assign idle_bit  = (state == PM_IDLE);
    assign pdown_bit = (state == PM_PDOWN);
endmodule

// File: rtl/pwr_mode_gate.sv
module pwr_mode_gate #(
    parameter int IRQ_W    = 4,
    parameter int RST_QUAL = 24,
    parameter int STAB_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_stby,
    input  logic              wr_idle,
    input  logic              wr_pdown,
    input  logic [IRQ_W-1:0]  irq_pend,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic              cmp_wake,
    input  logic              ext_rst,
    input  logic [STAB_W-1:0] stab_len,
    output logic              osc_run,
    output logic              clk_en_cpu,
    output logic              clk_en_acq,
    output logic              clk_en_disp,
    output logic              clk_en_per,
    output logic              rst_out,
    output logic              stby_bit,
    output logic              idle_bit,
    output logic              pdown_bit
);
    logic stab_load, stab_done;

    pmc_rst_qual #(.QUAL(RST_QUAL)) u_rst_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_rst (ext_rst),
        .rst_q   (rst_out)
    );

    pmc_stab_timer #(.W(STAB_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stab_load),
        .len   (stab_len),
        .done  (stab_done)
    );

    pmc_fsm #(.IRQ_W(IRQ_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_stby   (wr_stby),
        .wr_idle   (wr_idle),
        .wr_pdown  (wr_pdown),
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .cmp_wake  (cmp_wake),
        .rst_q     (rst_out),
        .stab_done (stab_done),
        .stab_load (stab_load),
        .osc_run   (osc_run),
        .en_cpu    (clk_en_cpu),
        .en_acq    (clk_en_acq),
        .en_disp   (clk_en_disp),
        .en_per    (clk_en_per),
        .stby_bit  (stby_bit),
        .idle_bit  (idle_bit),
        .pdown_bit (pdown_bit)
    );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int IRQ_W    = 4,
    parameter int RST_QUAL = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_idle,
    input logic             wr_pdown,
    input logic [IRQ_W-1:0] irq_pend,
    input logic [IRQ_W-1:0] irq_en,
    input logic             cmp_wake,
    input logic             ext_rst,
    input logic             osc_run,
    input logic             clk_en_cpu,
    input logic             clk_en_acq,
    input logic             clk_en_disp,
    input logic             clk_en_per,
    input logic             rst_out,
    input logic             stby_bit,
    input logic             idle_bit,
    input logic             pdown_bit
);
    localparam int CW = $clog2(RST_QUAL + 1);
    logic [CW-1:0] hi_run;
    logic irq_wake;

    assign irq_wake = |(irq_pend & irq_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     hi_run <= '0;
        else if (!ext_rst)              hi_run <= '0;
        else if (hi_run != CW'(RST_QUAL)) hi_run <= hi_run + 1'b1;
    end

    assert_stby_gating_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_cpu |-> (clk_en_acq == !stby_bit) && (clk_en_disp == !stby_bit) && clk_en_per && osc_run);

    assert_idle_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_bit |-> !clk_en_cpu && !clk_en_acq && !clk_en_disp && clk_en_per && osc_run);

    assert_pdown_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_bit |-> !osc_run && !clk_en_cpu && !clk_en_per && !clk_en_acq && !clk_en_disp);

    assert_stby_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_bit && stby_bit && (irq_wake || cmp_wake) && !rst_out) |=> (clk_en_cpu && stby_bit && !clk_en_acq));

    assert_irq_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_bit && irq_wake) |=> (!idle_bit && clk_en_cpu));

    assert_cmp_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_bit && cmp_wake) |=> (!idle_bit && clk_en_cpu));

    assert_rst_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == (hi_run >= CW'(RST_QUAL)));

    assert_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> (!stby_bit && !idle_bit && !pdown_bit));

    assert_osc_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_run) |-> (!clk_en_cpu && !clk_en_per && !clk_en_acq && !clk_en_disp));

    assert_pd_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_cpu && wr_en && wr_idle && wr_pdown && !rst_out) |=> (pdown_bit && !idle_bit));
endmodule

bind pwr_mode_gate pmc_chk #(.IRQ_W(IRQ_W), .RST_QUAL(RST_QUAL)) u_pmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idle     (wr_idle),
    .wr_pdown    (wr_pdown),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .cmp_wake    (cmp_wake),
    .ext_rst     (ext_rst),
    .osc_run     (osc_run),
    .clk_en_cpu  (clk_en_cpu),
    .clk_en_acq  (clk_en_acq),
    .clk_en_disp (clk_en_disp),
    .clk_en_per  (clk_en_per),
    .rst_out     (rst_out),
    .stby_bit    (stby_bit),
    .idle_bit    (idle_bit),
    .pdown_bit   (pdown_bit)
);

// File: tb/test_pwr_mode_gate.sv
`timescale 1ns/1ps
module test_pwr_mode_gate;
    localparam int IRQ_W = 4;
    localparam int QUAL  = 24;
    localparam int SW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_stby = 0, wr_idle = 0, wr_pdown = 0;
    logic [IRQ_W-1:0] irq_pend = '0, irq_en = '0;
    logic cmp_wake = 0, ext_rst = 0;
    logic [SW-1:0] stab_len = 16'd3;
    logic osc_run, clk_en_cpu, clk_en_acq, clk_en_disp, clk_en_per;
    logic rst_out, stby_bit, idle_bit, pdown_bit;

    int checks = 0, failures = 0;
    bit finished = 0;

    // bench model: 0 run, 1 idle, 2 power-down, 3 oscillator wait
    int m_state, m_stby, m_rcnt, m_rout, m_tcnt;

    always #2.5 clk = ~clk;

    pwr_mode_gate #(.IRQ_W(IRQ_W), .RST_QUAL(QUAL), .STAB_W(SW)) i_pwr_mode_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stby(wr_stby), .wr_idle(wr_idle),
        .wr_pdown(wr_pdown), .irq_pend(irq_pend), .irq_en(irq_en), .cmp_wake(cmp_wake),
        .ext_rst(ext_rst), .stab_len(stab_len), .osc_run(osc_run), .clk_en_cpu(clk_en_cpu),
        .clk_en_acq(clk_en_acq), .clk_en_disp(clk_en_disp), .clk_en_per(clk_en_per),
        .rst_out(rst_out), .stby_bit(stby_bit), .idle_bit(idle_bit), .pdown_bit(pdown_bit));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int next_state(int st, int stby_in, output int stby_out);
        int wake = ((irq_pend & irq_en) != 0 || cmp_wake) ? 1 : 0;
        int done = (m_tcnt == 0) ? 1 : 0;
        int n = st;
        stby_out = stby_in;
        if (m_rout != 0) begin
            stby_out = 0;
            if (st == 2 || st == 3) n = (st == 3 && done != 0) ? 0 : 3;
            else n = 0;
        end else begin
            case (st)
                0: if (wr_en) begin
                       stby_out = wr_stby;
                       n = wr_pdown ? 2 : (wr_idle ? 1 : 0);
                   end
                1: if (wake != 0) n = 0;
                2: if (wake != 0) n = 3;
                default: if (done != 0) n = 0;
            endcase
        end
        return n;
    endfunction

    task automatic model_step();
        int ns, nstby;
        if (!rst_n) begin
            m_state = 0; m_stby = 0; m_rcnt = 0; m_rout = 0; m_tcnt = 0;
            return;
        end
        ns = next_state(m_state, m_stby, nstby);
        if (ns == 3 && m_state != 3) m_tcnt = stab_len;
        else if (m_tcnt != 0) m_tcnt = m_tcnt - 1;
        m_rout = (ext_rst && m_rcnt >= QUAL - 1) ? 1 : 0;
        m_rcnt = ext_rst ? ((m_rcnt < QUAL) ? m_rcnt + 1 : m_rcnt) : 0;
        m_state = ns;
        m_stby = nstby;
    endtask

    task automatic compare();
        string tag;
        case (m_state)
            0: tag = "R1"; 1: tag = "R2"; 2: tag = "R3"; default: tag = "R9";
        endcase
        chk(tag, "osc_run", osc_run, m_state != 2);
        chk(tag, "clk_en_cpu", clk_en_cpu, m_state == 0);
        chk(tag, "clk_en_acq", clk_en_acq, m_state == 0 && m_stby == 0);
        chk(tag, "clk_en_disp", clk_en_disp, m_state == 0 && m_stby == 0);
        chk(tag, "clk_en_per", clk_en_per, m_state == 0 || m_state == 1);
        chk("R8", "stby_bit", stby_bit, m_stby);
        chk("R5", "idle_bit", idle_bit, m_state == 1);
        chk("R10", "pdown_bit", pdown_bit, m_state == 2);
        chk("R7", "rst_out", rst_out, m_rout);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle_in();
        wr_en = 0; wr_stby = 0; wr_idle = 0; wr_pdown = 0;
        irq_pend = '0; irq_en = '0; cmp_wake = 0; ext_rst = 0;
    endtask

    task automatic write(bit s, bit i, bit p);
        wr_en = 1; wr_stby = s; wr_idle = i; wr_pdown = p;
        tick();
        wr_en = 0; wr_stby = 0; wr_idle = 0; wr_pdown = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, burst;
        void'($urandom(32'd4711));
        idle_in();
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R8: reset state
        chk("R8", "reset cpu", clk_en_cpu, 1);
        chk("R8", "reset acq", clk_en_acq, 1);
        chk("R8", "reset bits", {stby_bit, idle_bit, pdown_bit}, 0);

        // R1: standby alone
        write(1, 0, 0);
        chk("R1", "stby acq off", clk_en_acq, 0);
        chk("R1", "stby cpu on", clk_en_cpu, 1);

        // R4 + R2: standby with idle, masked interrupt ignored (R5)
        write(1, 1, 0);
        chk("R2", "idle cpu off", clk_en_cpu, 0);
        irq_pend = 4'b0010; irq_en = 4'b0100;
        tick();
        chk("R5", "masked irq keeps idle", idle_bit, 1);
        irq_en = 4'b0010;
        tick();
        idle_in();
        chk("R5", "enabled irq clears idle", idle_bit, 0);
        chk("R4", "cpu back after wake", clk_en_cpu, 1);
        chk("R4", "acq stays gated", clk_en_acq, 0);

        // R6: compare wake
        write(0, 1, 0);
        cmp_wake = 1;
        tick();
        idle_in();
        chk("R6", "cmp wake cpu", clk_en_cpu, 1);
        chk("R6", "acq back with stby clear", clk_en_acq, 1);

        // R11: idle and power-down together
        write(0, 1, 1);
        chk("R11", "pdown taken", pdown_bit, 1);
        chk("R11", "idle not set", idle_bit, 0);
        chk("R3", "osc stopped", osc_run, 0);

        // R12: write ignored while the CPU is gated
        write(1, 1, 0);
        chk("R12", "stby unchanged", stby_bit, 0);
        chk("R12", "still pdown", pdown_bit, 1);

        // R10 + R9: wake from power-down, count stabilization window
        stab_len = 16'd3;
        irq_pend = 4'b1000; irq_en = 4'b1000;
        tick();
        idle_in();
        chk("R10", "osc restarted", osc_run, 1);
        n = 0;
        while (!clk_en_cpu && n < 50) begin
            if (osc_run) n++;
            tick();
        end
        chk("R9", "stab window len", n, 4);

        // R7: 23 high samples do not qualify, 24 do
        ext_rst = 1;
        repeat (23) tick();
        chk("R7", "23 samples", rst_out, 0);
        ext_rst = 0;
        tick();
        write(0, 1, 0);
        ext_rst = 1;
        repeat (23) tick();
        chk("R7", "still idle before qual", idle_bit, 1);
        tick();
        chk("R7", "24 samples", rst_out, 1);
        tick();
        chk("R8", "reset ends idle", idle_bit, 0);
        ext_rst = 0;
        tick();

        // R10: reset exit from power-down
        write(1, 0, 1);
        stab_len = 16'd0;
        ext_rst = 1;
        repeat (25) tick();
        chk("R10", "reset leaves pdown", pdown_bit, 0);
        chk("R8", "reset clears stby", stby_bit, 0);
        ext_rst = 0;
        repeat (3) tick();
        chk("R9", "run after zero stab", clk_en_cpu, 1);

        // random phase
        burst = 0;
        for (int c = 0; c < 4000; c++) begin
            wr_en = ($urandom % 6) == 0;
            wr_stby = $urandom % 2;
            wr_idle = $urandom % 2;
            wr_pdown = ($urandom % 3) == 0;
            irq_pend = IRQ_W'($urandom);
            irq_en = (($urandom % 4) == 0) ? IRQ_W'($urandom) : '0;
            cmp_wake = ($urandom % 20) == 0;
            if ((c % 50) == 0) stab_len = SW'($urandom % 7);
            if (burst > 0) begin
                ext_rst = 1; burst--;
            end else begin
                ext_rst = 0;
                if (($urandom % 150) == 0) burst = 15 + ($urandom % 20);
            end
            tick();
        end
        idle_in();
        tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule